// File: doc/BRIEF.md
# Short-Address Register Window Translator

This block sits between the operand decode stage of a 16-bit microcontroller core and its peripheral register bus. It turns the short 8-bit register operands used by compact instruction forms into full 24-bit long addresses, and it decides whether a given short operand really names one of the sixteen general-purpose registers. Instructions that already carry a full 16-bit address, or that reach the register space through a pointer, pass through unchanged.

Two 512-byte register areas exist. The standard area starts at 0x00FE00 and the extended area starts at 0x00F000. A short operand normally lands in the standard area. An extend command with a length field opens a scope. For that many retired instructions, short and direct-bit operands land in the extended area instead. The scope then closes by itself. Short forms cannot reach the high byte of a register, so such requests are flagged as errors. Every result is registered and appears one cycle after the request.

Top module: `regwin_xlate`

## Requirements
- R1: While rst_n is low, out_valid, out_addr, out_lane, out_gpr, out_gpr_idx, out_ext and out_err are all zero, and the extend scope is closed.
- R2: With the scope closed, a valid short request (req_kind 0) whose offset is below 0xF0 gives out_addr = 0x00FE00 + 2*offset. out_lane is 3 (word) for a word access and 1 (low byte) for a byte access with req_hi low.
- R3: A short request with req_byte and req_hi both high is rejected. out_err is 1, and out_addr, out_lane, out_gpr, out_gpr_idx and out_ext are 0.
- R4: ext_cmd opens a scope of ext_len+1 instructions. A request in the same cycle as ext_cmd is translated in the old mode. Requests after it and up to and including the cycle of the (ext_len+1)-th retire strobe use base 0x00F000 and set out_ext.
- R5: Once the scope has counted down to zero, short and bit requests use the standard base again, with no further command.
- R6: ext_cmd issued while a scope is open reloads the count with the new length. When ext_cmd and instr_retire are high in the same cycle, the reload wins and that retire is not counted.
- R7: instr_retire while no scope is open changes nothing. Later short requests still use the standard base.
- R8: Long (req_kind 2) and indirect (req_kind 3) requests give out_addr = {8'h00, req_long_addr} whatever the scope state. out_ext and out_err are 0. out_lane is 3 for a word access, 1 for a low byte and 2 for a high byte.
- R9: A short or bit offset in 0xF0..0xFF names register R(offset-0xF0) in either mode. out_gpr is 1, out_gpr_idx is offset[3:0], out_addr is 0 and out_ext is 0. out_lane is 1 for a short low-byte access and 3 otherwise.
- R10: out_valid equals req_valid of the previous cycle. While out_valid is 0, every other output is 0.
- R11: A direct-bit request (req_kind 1) follows the same base and register rules as a short one. Its out_lane is always 3, and req_byte and req_hi have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 short, 1 direct bit, 2 long, 3 indirect |
| req_offset | input | 8 | Short word offset |
| req_long_addr | input | 16 | Full address for long and indirect forms |
| req_byte | input | 1 | Byte access (0 = word) |
| req_hi | input | 1 | High byte selected for a byte access |
| ext_cmd | input | 1 | Open or reload the extend scope |
| ext_len | input | 2 | Scope length minus one |
| instr_retire | input | 1 | One instruction retired |
| out_valid | output | 1 | Result valid |
| out_addr | output | 24 | Translated long address |
| out_lane | output | 2 | Byte lanes: bit0 low, bit1 high |
| out_gpr | output | 1 | Operand is a general-purpose register |
| out_gpr_idx | output | 4 | Register number when out_gpr is set |
| out_ext | output | 1 | Extended area used |
| out_err | output | 1 | Forbidden short high-byte access |

## Verification
Some properties are checked on every cycle. These are the one-cycle valid latency with zeroed idle outputs, the clean error response, the pass-through of long and indirect addresses, and the exclusivity of a register hit. The scope count is also tracked against the command and retire inputs at every edge, and out_ext may rise only while the count is non-zero. Other behaviour shows only through the bench's scenarios and its per-clock reference model. This covers the exact instruction on which a scope ends, the same-cycle command and retire case, a request arriving with its own command, and the register aliasing holding inside an open scope.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   typedef enum logic [1:0] {
      ACC_SHORT = 2'd0,
      ACC_BIT   = 2'd1,
      ACC_LONG  = 2'd2,
      ACC_INDIR = 2'd3
   } acc_kind_e;

   localparam logic [1:0] LANE_NONE = 2'b00;
   localparam logic [1:0] LANE_LO   = 2'b01;
   localparam logic [1:0] LANE_HI   = 2'b10;
   localparam logic [1:0] LANE_WORD = 2'b11;

   typedef struct packed {
      logic [1:0] lane;
      logic       gpr;
      logic       ext;
      logic       err;
   } xl_flags_t;

endpackage

// File: rtl/regwin_scope.sv
module regwin_scope #(
   parameter int MAX_SCOPE = 4,
   localparam int LEN_W = $clog2(MAX_SCOPE),
   localparam int CNT_W = $clog2(MAX_SCOPE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_cmd,
   input  logic [LEN_W-1:0] ext_len,
   input  logic             retire,
   output logic [CNT_W-1:0] cnt,
   output logic             active
);

   logic [CNT_W-1:0] load_val;

   generate
      if (MAX_SCOPE == (1 << LEN_W)) begin : g_exact
         assign load_val = CNT_W'(ext_len) + CNT_W'(1);
      end else begin : g_clamp
         assign load_val = (CNT_W'(ext_len) >= CNT_W'(MAX_SCOPE)) ?
                           CNT_W'(MAX_SCOPE) : CNT_W'(ext_len) + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ext_cmd) begin
         cnt <= load_val;
      end else if (retire && (cnt != '0)) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign active = (cnt != '0);

endmodule

// File: rtl/regwin_decode.sv
module regwin_decode
   import regwin_pkg::*;
#(
   parameter int              ADDR_W    = 24,
   parameter int              OFS_W     = 8,
   parameter int              LONG_W    = 16,
   parameter logic [23:0]     STD_BASE  = 24'h00FE00,
   parameter logic [23:0]     EXT_BASE  = 24'h00F000,
   parameter int              GPR_N     = 16,
   parameter int              GPR_FIRST = 240,
   parameter bit              GPR_EN    = 1'b1,
   localparam int             GIDX_W    = $clog2(GPR_N)
) (
   input  acc_kind_e          kind,
   input  logic [OFS_W-1:0]   ofs,
   input  logic [LONG_W-1:0]  long_addr,
   input  logic               byte_acc,
   input  logic               hi_sel,
   input  logic               win_ext,
   output logic [ADDR_W-1:0]  addr,
   output logic [GIDX_W-1:0]  gpr_idx,
   output xl_flags_t          flags
);

   logic              is_gpr;
   logic              short_form;
   logic              hb_reject;
   logic [ADDR_W-1:0] ofs_bytes;
   logic [ADDR_W-1:0] base;
   logic [1:0]        short_lane;

   generate
      if (GPR_EN) begin : g_gpr_alias
         assign is_gpr = (ofs >= OFS_W'(GPR_FIRST));
      end else begin : g_gpr_none
         assign is_gpr = 1'b0;
      end
   endgenerate

   assign short_form = (kind == ACC_SHORT) || (kind == ACC_BIT);
   assign hb_reject  = (kind == ACC_SHORT) && byte_acc && hi_sel;
   assign ofs_bytes  = ADDR_W'({ofs, 1'b0});
   assign base       = win_ext ? ADDR_W'(EXT_BASE) : ADDR_W'(STD_BASE);
   assign short_lane = ((kind == ACC_SHORT) && byte_acc) ? LANE_LO : LANE_WORD;

   always_comb begin
      addr    = '0;
      gpr_idx = '0;
      flags   = '0;
      if (short_form) begin
         if (hb_reject) begin
            flags.err = 1'b1;
         end else if (is_gpr) begin
            flags.gpr  = 1'b1;
            flags.lane = short_lane;
            gpr_idx    = ofs[GIDX_W-1:0];
         end else begin
            flags.ext  = win_ext;
            flags.lane = short_lane;
            addr       = base + ofs_bytes;
         end
      end else begin
         addr = ADDR_W'(long_addr);
         if (!byte_acc) begin
            flags.lane = LANE_WORD;
         end else begin
            flags.lane = hi_sel ? LANE_HI : LANE_LO;
         end
      end
   end

endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
   import regwin_pkg::*;
#(
   parameter int          ADDR_W    = 24,
   parameter int          OFS_W     = 8,
   parameter int          LONG_W    = 16,
   parameter logic [23:0] STD_BASE  = 24'h00FE00,
   parameter logic [23:0] EXT_BASE  = 24'h00F000,
   parameter int          GPR_N     = 16,
   parameter int          GPR_FIRST = 240,
   parameter bit          GPR_EN    = 1'b1,
   parameter int          MAX_SCOPE = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [1:0]                   req_kind,
   input  logic [OFS_W-1:0]             req_offset,
   input  logic [LONG_W-1:0]            req_long_addr,
   input  logic                         req_byte,
   input  logic                         req_hi,
   input  logic                         ext_cmd,
   input  logic [$clog2(MAX_SCOPE)-1:0] ext_len,
   input  logic                         instr_retire,
   output logic                         out_valid,
   output logic [ADDR_W-1:0]            out_addr,
   output logic [1:0]                   out_lane,
   output logic                         out_gpr,
   output logic [$clog2(GPR_N)-1:0]     out_gpr_idx,
   output logic                         out_ext,
   output logic                         out_err
);

   localparam int GIDX_W = $clog2(GPR_N);
   localparam int CNT_W  = $clog2(MAX_SCOPE + 1);

   initial begin
      assert (MAX_SCOPE >= 2) else $fatal(1, "MAX_SCOPE must be at least 2");
      assert (LONG_W <= ADDR_W) else $fatal(1, "LONG_W wider than ADDR_W");
      assert (OFS_W + 1 <= ADDR_W) else $fatal(1, "offset does not fit ADDR_W");
      assert (GPR_FIRST % GPR_N == 0) else $fatal(1, "GPR_FIRST not aligned");
      assert (GPR_FIRST + GPR_N == (1 << OFS_W)) else $fatal(1, "GPR range must end the offset space");
   end

   logic [CNT_W-1:0]  scope_cnt;
   logic              scope_active;
   logic [ADDR_W-1:0] d_addr;
   logic [GIDX_W-1:0] d_idx;
   xl_flags_t         d_flags;

   regwin_scope #(.MAX_SCOPE(MAX_SCOPE)) u_scope (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_cmd (ext_cmd),
      .ext_len (ext_len),
      .retire  (instr_retire),
      .cnt     (scope_cnt),
      .active  (scope_active)
   );

   regwin_decode #(
      .ADDR_W    (ADDR_W),
      .OFS_W     (OFS_W),
      .LONG_W    (LONG_W),
      .STD_BASE  (STD_BASE),
      .EXT_BASE  (EXT_BASE),
      .GPR_N     (GPR_N),
      .GPR_FIRST (GPR_FIRST),
      .GPR_EN    (GPR_EN)
   ) u_decode (
      .kind      (acc_kind_e'(req_kind)),
      .ofs       (req_offset),
      .long_addr (req_long_addr),
      .byte_acc  (req_byte),
      .hi_sel    (req_hi),
      .win_ext   (scope_active),
      .addr      (d_addr),
      .gpr_idx   (d_idx),
      .flags     (d_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_addr    <= '0;
         out_lane    <= LANE_NONE;
         out_gpr     <= 1'b0;
         out_gpr_idx <= '0;
         out_ext     <= 1'b0;
         out_err     <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_addr    <= d_addr;
            out_lane    <= d_flags.lane;
            out_gpr     <= d_flags.gpr;
            out_gpr_idx <= d_idx;
            out_ext     <= d_flags.ext;
            out_err     <= d_flags.err;
         end else begin
            out_addr    <= '0;
            out_lane    <= LANE_NONE;
            out_gpr     <= 1'b0;
            out_gpr_idx <= '0;
            out_ext     <= 1'b0;
            out_err     <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/regwin_xlate_chk.sv
module regwin_xlate_chk #(
   parameter int          ADDR_W    = 24,
   parameter int          OFS_W     = 8,
   parameter int          LONG_W    = 16,
   parameter logic [23:0] EXT_BASE  = 24'h00F000,
   parameter int          GPR_N     = 16,
   parameter int          MAX_SCOPE = 4,
   localparam int         LEN_W     = $clog2(MAX_SCOPE),
   localparam int         CNT_W     = $clog2(MAX_SCOPE + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [1:0]           req_kind,
   input logic [LONG_W-1:0]    req_long_addr,
   input logic                 req_byte,
   input logic                 req_hi,
   input logic                 ext_cmd,
   input logic [LEN_W-1:0]     ext_len,
   input logic                 instr_retire,
   input logic [CNT_W-1:0]     cnt,
   input logic                 out_valid,
   input logic [ADDR_W-1:0]    out_addr,
   input logic [1:0]           out_lane,
   input logic                 out_gpr,
   input logic [$clog2(GPR_N)-1:0] out_gpr_idx,
   input logic                 out_ext,
   input logic                 out_err
);

   localparam logic [ADDR_W-1:0] EXT_LO = ADDR_W'(EXT_BASE);
   localparam logic [ADDR_W-1:0] EXT_HI = ADDR_W'(EXT_BASE) + ADDR_W'((1 << (OFS_W + 1)) - 2);

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(req_valid)));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_addr == '0 && out_lane == 2'b00 && !out_gpr &&
                      out_gpr_idx == '0 && !out_ext && !out_err));

   assert_hibyte_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_valid && req_kind == 2'd0 && req_byte && req_hi)) |-> out_err);

   assert_err_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_addr == '0 && out_lane == 2'b00 && !out_gpr && !out_ext));

   assert_long_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_valid && req_kind[1])) |->
         (out_addr == ADDR_W'($past(req_long_addr)) && !out_ext && !out_err && !out_gpr));

   assert_gpr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_gpr |-> (!out_ext && !out_err && out_addr == '0));

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cmd |=> (cnt == CNT_W'($past(ext_len)) + CNT_W'(1)));

   assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_cmd && instr_retire && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_cmd && (!instr_retire || cnt == '0)) |=> $stable(cnt));

   assert_ext_scope_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_ext) |-> ($past(cnt) != '0 && out_addr >= EXT_LO && out_addr <= EXT_HI));

endmodule

bind regwin_xlate regwin_xlate_chk #(
   .ADDR_W    (ADDR_W),
   .OFS_W     (OFS_W),
   .LONG_W    (LONG_W),
   .EXT_BASE  (EXT_BASE),
   .GPR_N     (GPR_N),
   .MAX_SCOPE (MAX_SCOPE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_kind      (req_kind),
   .req_long_addr (req_long_addr),
   .req_byte      (req_byte),
   .req_hi        (req_hi),
   .ext_cmd       (ext_cmd),
   .ext_len       (ext_len),
   .instr_retire  (instr_retire),
   .cnt           (scope_cnt),
   .out_valid     (out_valid),
   .out_addr      (out_addr),
   .out_lane      (out_lane),
   .out_gpr       (out_gpr),
   .out_gpr_idx   (out_gpr_idx),
   .out_ext       (out_ext),
   .out_err       (out_err)
);

// File: tb/regwin_xlate_bench.sv
module regwin_xlate_bench;

   localparam logic [1:0] K_SHORT = 2'd0;
   localparam logic [1:0] K_BIT   = 2'd1;
   localparam logic [1:0] K_LONG  = 2'd2;
   localparam logic [1:0] K_INDIR = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [7:0]  req_offset = 8'd0;
   logic [15:0] req_long_addr = 16'd0;
   logic        req_byte = 1'b0;
   logic        req_hi = 1'b0;
   logic        ext_cmd = 1'b0;
   logic [1:0]  ext_len = 2'd0;
   logic        instr_retire = 1'b0;

   logic        out_valid;
   logic [23:0] out_addr;
   logic [1:0]  out_lane;
   logic        out_gpr;
   logic [3:0]  out_gpr_idx;
   logic        out_ext;
   logic        out_err;

   always #5 clk = ~clk;

   regwin_xlate u_regwin_xlate (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_kind      (req_kind),
      .req_offset    (req_offset),
      .req_long_addr (req_long_addr),
      .req_byte      (req_byte),
      .req_hi        (req_hi),
      .ext_cmd       (ext_cmd),
      .ext_len       (ext_len),
      .instr_retire  (instr_retire),
      .out_valid     (out_valid),
      .out_addr      (out_addr),
      .out_lane      (out_lane),
      .out_gpr       (out_gpr),
      .out_gpr_idx   (out_gpr_idx),
      .out_ext       (out_ext),
      .out_err       (out_err)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   // behavioural reference model
   int    scope = 0;
   int    e_valid, e_addr, e_lane, e_gpr, e_idx, e_ext, e_err;
   string e_tag = "R1";

   always @(posedge clk) begin
      e_tag = cur_tag;
      e_valid = 0; e_addr = 0; e_lane = 0; e_gpr = 0; e_idx = 0; e_ext = 0; e_err = 0;
      if (!rst_n) begin
         scope = 0;
      end else begin
         e_valid = int'(req_valid);
         if (req_valid) begin
            if (req_kind == K_LONG || req_kind == K_INDIR) begin
               e_addr = int'(req_long_addr);
               e_lane = !req_byte ? 3 : (req_hi ? 2 : 1);
            end else if (req_kind == K_SHORT && req_byte && req_hi) begin
               e_err = 1;
            end else begin
               e_lane = (req_kind == K_SHORT && req_byte) ? 1 : 3;
               if (req_offset >= 8'hF0) begin
                  e_gpr = 1;
                  e_idx = int'(req_offset) - 240;
               end else begin
                  e_ext  = (scope > 0) ? 1 : 0;
                  e_addr = ((scope > 0) ? 'hF000 : 'hFE00) + 2 * int'(req_offset);
               end
            end
         end
         if (ext_cmd) scope = int'(ext_len) + 1;
         else if (instr_retire && scope > 0) scope = scope - 1;
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         checks++;
         if (int'(out_valid) != e_valid || int'(out_addr) != e_addr ||
             int'(out_lane) != e_lane || int'(out_gpr) != e_gpr ||
             int'(out_gpr_idx) != e_idx || int'(out_ext) != e_ext ||
             int'(out_err) != e_err) begin
            errors++;
            $display("FAIL %s model: got v=%0d a=%06h l=%0d g=%0d i=%0d x=%0d e=%0d exp v=%0d a=%06h l=%0d g=%0d i=%0d x=%0d e=%0d",
                     e_tag, out_valid, out_addr, out_lane, out_gpr, out_gpr_idx, out_ext, out_err,
                     e_valid, e_addr, e_lane, e_gpr, e_idx, e_ext, e_err);
         end
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic put(input logic [1:0] k, input int ofs, input int lng, input bit byt, input bit hi);
      req_valid = 1'b1; req_kind = k; req_offset = 8'(ofs);
      req_long_addr = 16'(lng); req_byte = byt; req_hi = hi;
   endtask

   task automatic idle();
      req_valid = 1'b0; req_kind = 2'd0; req_offset = 8'd0;
      req_long_addr = 16'd0; req_byte = 1'b0; req_hi = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL R10 watchdog: got hung exp finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cur_tag = "R1";
      repeat (3) tick();
      chk("R1", "valid in reset", int'(out_valid), 0);
      chk("R1", "addr in reset", int'(out_addr), 0);
      rst_n = 1'b1;
      // R10 idle output
      cur_tag = "R10";
      tick();
      chk("R10", "idle valid", int'(out_valid), 0);
      // R2 standard short
      cur_tag = "R2";
      put(K_SHORT, 'h10, 0, 0, 0); tick();
      chk("R2", "std word addr", int'(out_addr), 'hFE20);
      chk("R2", "std word lane", int'(out_lane), 3);
      put(K_SHORT, 'hEF, 0, 1, 0); tick();
      chk("R2", "std low addr", int'(out_addr), 'hFFDE);
      chk("R2", "std low lane", int'(out_lane), 1);
      // R3 high byte rejected
      cur_tag = "R3";
      put(K_SHORT, 'h20, 0, 1, 1); tick();
      chk("R3", "hi err", int'(out_err), 1);
      chk("R3", "hi lane", int'(out_lane), 0);
      // R7 retire without scope
      cur_tag = "R7";
      idle(); instr_retire = 1'b1; repeat (3) tick(); instr_retire = 1'b0;
      put(K_SHORT, 'h01, 0, 0, 0); tick();
      chk("R7", "no scope ext", int'(out_ext), 0);
      chk("R7", "no scope addr", int'(out_addr), 'hFE02);
      // R4 scope of two, request alongside the command uses old mode
      cur_tag = "R4";
      put(K_SHORT, 'h10, 0, 0, 0); ext_cmd = 1'b1; ext_len = 2'd1; tick();
      chk("R4", "same-cycle addr", int'(out_addr), 'hFE20);
      ext_cmd = 1'b0; instr_retire = 1'b1; put(K_SHORT, 'h10, 0, 0, 0); tick();
      chk("R4", "ext addr", int'(out_addr), 'hF020);
      chk("R4", "ext flag", int'(out_ext), 1);
      cur_tag = "R11";
      put(K_BIT, 'h30, 0, 1, 1); tick();
      chk("R11", "bit ext addr", int'(out_addr), 'hF060);
      chk("R11", "bit lane", int'(out_lane), 3);
      chk("R11", "bit no err", int'(out_err), 0);
      cur_tag = "R5";
      instr_retire = 1'b0; put(K_SHORT, 'h10, 0, 0, 0); tick();
      chk("R5", "fallback addr", int'(out_addr), 'hFE20);
      chk("R5", "fallback ext", int'(out_ext), 0);
      // R6 reload, load wins over same-cycle retire
      cur_tag = "R6";
      idle(); ext_cmd = 1'b1; ext_len = 2'd3; tick();
      ext_cmd = 1'b0; instr_retire = 1'b1; tick();
      ext_cmd = 1'b1; ext_len = 2'd0; instr_retire = 1'b1; tick();
      ext_cmd = 1'b0; instr_retire = 1'b0; put(K_SHORT, 'h02, 0, 0, 0); tick();
      chk("R6", "reloaded ext", int'(out_addr), 'hF004);
      instr_retire = 1'b1; tick();
      chk("R6", "last scoped ext", int'(out_ext), 1);
      instr_retire = 1'b0; tick();
      chk("R6", "after reload end", int'(out_addr), 'hFE04);
      // R8 long and indirect inside a scope
      cur_tag = "R8";
      idle(); ext_cmd = 1'b1; ext_len = 2'd3; tick(); ext_cmd = 1'b0;
      put(K_LONG, 0, 'h1235, 1, 1); tick();
      chk("R8", "long addr", int'(out_addr), 'h1235);
      chk("R8", "long hi lane", int'(out_lane), 2);
      chk("R8", "long no err", int'(out_err), 0);
      put(K_INDIR, 0, 'hFE40, 0, 0); tick();
      chk("R8", "indir addr", int'(out_addr), 'hFE40);
      chk("R8", "indir ext", int'(out_ext), 0);
      // R9 GPR aliasing in both modes
      cur_tag = "R9";
      put(K_SHORT, 'hF3, 0, 0, 0); tick();
      chk("R9", "gpr in ext", int'(out_gpr), 1);
      chk("R9", "gpr idx", int'(out_gpr_idx), 3);
      chk("R9", "gpr no ext", int'(out_ext), 0);
      idle(); instr_retire = 1'b1; repeat (4) tick(); instr_retire = 1'b0;
      put(K_SHORT, 'hFC, 0, 1, 0); tick();
      chk("R9", "gpr std idx", int'(out_gpr_idx), 12);
      chk("R9", "gpr low lane", int'(out_lane), 1);
      chk("R9", "gpr addr", int'(out_addr), 0);
      // mixed traffic against the reference model
      cur_tag = "R10";
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 5) != 0)
            put(2'($urandom), int'($urandom % 256), int'($urandom), 1'($urandom), 1'($urandom));
         else
            idle();
         ext_cmd = (($urandom % 10) == 0);
         ext_len = 2'($urandom);
         instr_retire = 1'($urandom);
         tick();
      end
      idle(); ext_cmd = 1'b0; instr_retire = 1'b0; tick(); tick();
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule